// File: doc/BRIEF.md
# Parameter Bus Register Master

This block sits on the front-end side of a serial slow-control link. It receives decoded commands, each carrying a 7-bit register address, a direction and, for writes, a data byte. It turns each command into one cycle on a simple parallel parameter bus. That bus has an address, a write-data byte, a read-data byte, a direction line and a one-clock enable strobe, and it drives the front-end configuration registers.

The bridge holds no register copies of its own. A write lands at the same address it named. A read runs one bus cycle and samples the register value during the strobe. It then offers a reply that carries both the address and the byte read, and holds that reply until the link side accepts it. A bulk-transfer flag sends a command's byte to the fixed stream address 0x00 as a write, whatever the address and direction fields say. A file therefore streams into the front end one byte per command.

Setup and hold lengths are parameters. The defaults are 3 setup and 4 hold clocks for reads, and 1 setup and 1 hold clock for writes.

Top module: `pbus_master`

## Requirements
- R1: During synchronous active-high reset, and on the first cycle after it, `pb_en` is 0, `pb_rd_nwr` is 1 (read), `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: A write command (`cmd_write`=1) drives `pb_addr`=`cmd_addr`, `pb_wdata`=`cmd_wdata` and `pb_rd_nwr`=0 for WR_SETUP clocks. `pb_en` is then high for exactly one clock, and address, data and direction are held for WR_HOLD further clocks.
- R3: A read command (`cmd_write`=0) drives `pb_addr`=`cmd_addr` and `pb_rd_nwr`=1 for RD_SETUP clocks. `pb_en` is then high for exactly one clock, and address and direction are held for RD_HOLD further clocks.
- R4: On a read, `pb_rdata` is sampled in the clock where `pb_en` is high. The reply then offers `rsp_addr` equal to the requested address and `rsp_data` equal to the sampled byte.
- R5: `cmd_ready` is 1 only in idle. It drops on the clock after a command is accepted (`cmd_valid`&&`cmd_ready`) and stays 0 until the cycle ends. For a read, the cycle ends when its reply is accepted.
- R6: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_addr` and `rsp_data` stay unchanged. The reply is dropped on the clock after `rsp_ready` is seen high.
- R7: A command with `cmd_bulk`=1 is always a write to address 0x00. `cmd_addr` and `cmd_write` are ignored, and `cmd_wdata` is written.
- R8: `pb_en` pulses exactly once per accepted command and never while no command is in progress.
- R9: After a write cycle completes, the bridge returns to idle with `pb_rd_nwr`=1 and `cmd_ready`=1 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Bridge idle, command accepted this clock if valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_bulk | input | 1 | Stream byte to address 0x00 as a write |
| cmd_addr | input | 7 | Register address |
| cmd_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read reply present |
| rsp_ready | input | 1 | Link side accepts the reply |
| rsp_addr | output | 7 | Address of the register read |
| rsp_data | output | 8 | Byte read |
| pb_addr | output | 7 | Parameter bus address |
| pb_wdata | output | 8 | Parameter bus write data |
| pb_rdata | input | 8 | Parameter bus read data |
| pb_rd_nwr | output | 1 | Direction: 1 = read, 0 = write |
| pb_en | output | 1 | One-clock enable strobe |

## Verification
The clock edge that accepts a command is counted as cycle 0. The new address is visible in cycle 1. The strobe falls in cycle SETUP+1. The hold runs through cycle SETUP+HOLD+1. In cycle SETUP+HOLD+2 the bridge shows either idle (after a write) or a valid reply (after a read). The bench counts these cycles from the acceptance edge with the default lengths. It samples at each falling edge and compares the strobe, address, direction and data in every cycle of every command. The far-side register model returns a value computed from the address only while the strobe is high, and a filler byte otherwise. A reply that shows the right byte therefore proves the sample was taken in the strobe clock.

// File: rtl/pbus_master.sv
module pbus_master #(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int RD_SETUP  = 3,
  parameter int RD_HOLD   = 4,
  parameter int WR_SETUP  = 1,
  parameter int WR_HOLD   = 1,
  parameter int BULK_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic              cmd_bulk,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] pb_addr,
  output logic [DATA_W-1:0] pb_wdata,
  input  logic [DATA_W-1:0] pb_rdata,
  output logic              pb_rd_nwr,
  output logic              pb_en
);

  localparam int MAX_S = (RD_SETUP > WR_SETUP) ? RD_SETUP : WR_SETUP;
  localparam int MAX_H = (RD_HOLD > WR_HOLD) ? RD_HOLD : WR_HOLD;
  localparam int MAX_T = (MAX_S > MAX_H) ? MAX_S : MAX_H;
  localparam int CNT_W = (MAX_T > 1) ? $clog2(MAX_T) : 1;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_REPLY} state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic              is_wr;

  assign is_wr     = cmd_write | cmd_bulk;
  assign pb_en     = (state == S_STROBE);
  assign cmd_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_REPLY);
  assign rsp_addr  = pb_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      pb_addr   <= '0;
      pb_wdata  <= '0;
      pb_rd_nwr <= 1'b1;
      rsp_data  <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          pb_addr   <= cmd_bulk ? ADDR_W'(BULK_ADDR) : cmd_addr;
          pb_wdata  <= cmd_wdata;
          pb_rd_nwr <= ~is_wr;
          cnt       <= is_wr ? CNT_W'(WR_SETUP - 1) : CNT_W'(RD_SETUP - 1);
          state     <= S_SETUP;
        end
        S_SETUP: begin
          if (cnt == '0) state <= S_STROBE;
          else           cnt   <= cnt - 1'b1;
        end
        S_STROBE: begin
          if (pb_rd_nwr) rsp_data <= pb_rdata;
          cnt   <= pb_rd_nwr ? CNT_W'(RD_HOLD - 1) : CNT_W'(WR_HOLD - 1);
          state <= S_HOLD;
        end
        S_HOLD: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (pb_rd_nwr) state <= S_REPLY;
          else begin
            state     <= S_IDLE;
            pb_rd_nwr <= 1'b1;
          end
        end
        S_REPLY: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !pb_en && pb_rd_nwr && cmd_ready && !rsp_valid); // R1
  AST_ADDR_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && !cmd_bulk |=> pb_addr == $past(cmd_addr)); // R2
  AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
    pb_en |-> $stable(pb_addr) && $stable(pb_rd_nwr) && $stable(pb_wdata)); // R3
  AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    pb_en |=> $stable(pb_addr) && $stable(pb_rd_nwr) && $stable(pb_wdata)); // R3
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> !cmd_ready); // R5
  AST_REPLY_STABLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_data)); // R6
  AST_REPLY_DROPS: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_ready |=> !rsp_valid && cmd_ready); // R6
  AST_BULK_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && cmd_bulk |=> pb_addr == ADDR_W'(BULK_ADDR) && !pb_rd_nwr); // R7
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pb_en |=> !pb_en); // R8
  AST_NO_IDLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !pb_en && !rsp_valid); // R8

endmodule

// File: tb/pbus_master_tb.sv
module pbus_master_tb_top;
  localparam int RS = 3, RH = 4, WS = 1, WH = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, cmd_bulk = 1'b0, rsp_ready = 1'b0;
  logic [6:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, pb_rd_nwr, pb_en;
  logic [6:0] rsp_addr, pb_addr;
  logic [7:0] rsp_data, pb_wdata, pb_rdata;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] regval(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  assign pb_rdata = pb_en ? regval(int'(pb_addr)) : 8'hEE;

  pbus_master dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_bulk(cmd_bulk), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .pb_addr(pb_addr), .pb_wdata(pb_wdata), .pb_rdata(pb_rdata),
    .pb_rd_nwr(pb_rd_nwr), .pb_en(pb_en)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic run_cmd(input bit wr, input bit bulk, input int addr, input int data, input int wait_n);
    bit ew = wr | bulk;
    int ea = bulk ? 0 : addr;
    int s = ew ? WS : RS;
    int h = ew ? WH : RH;
    string rq = bulk ? "R7" : (ew ? "R2" : "R3");
    @(negedge clk);
    check(cmd_ready == 1'b1, "R5", "ready in idle", int'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_write = wr; cmd_bulk = bulk;
    cmd_addr = 7'(addr); cmd_wdata = 8'(data);
    for (int k = 1; k <= s + h + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin
        cmd_valid = 1'b0; cmd_write = ~wr; cmd_bulk = 1'b0;
        cmd_addr = ~7'(addr); cmd_wdata = ~8'(data);
      end
      check(pb_en == (k == s + 1), "R8", "strobe position", int'(pb_en), int'(k == s + 1));
      check(pb_addr == 7'(ea), rq, "bus address", int'(pb_addr), ea);
      check(pb_rd_nwr == !ew, rq, "direction", int'(pb_rd_nwr), int'(!ew));
      if (ew) check(pb_wdata == 8'(data), rq, "write data", int'(pb_wdata), data & 255);
      check(cmd_ready == 1'b0, "R5", "busy not ready", int'(cmd_ready), 0);
      check(rsp_valid == 1'b0, "R4", "no early reply", int'(rsp_valid), 0);
    end
    @(negedge clk);
    if (ew) begin
      check(cmd_ready == 1'b1, "R9", "idle after write", int'(cmd_ready), 1);
      check(pb_rd_nwr == 1'b1, "R9", "direction back to read", int'(pb_rd_nwr), 1);
    end else begin
      for (int w = 0; w <= wait_n; w++) begin
        string rr = (w == 0) ? "R4" : "R6";
        check(rsp_valid == 1'b1, rr, "reply valid", int'(rsp_valid), 1);
        check(rsp_addr == 7'(addr), rr, "reply address", int'(rsp_addr), addr);
        check(rsp_data == regval(addr), rr, "reply data", int'(rsp_data), int'(regval(addr)));
        check(cmd_ready == 1'b0, "R5", "not ready during reply", int'(cmd_ready), 0);
        if (w == wait_n) rsp_ready = 1'b1;
        @(negedge clk);
      end
      rsp_ready = 1'b0;
      check(rsp_valid == 1'b0, "R6", "reply dropped", int'(rsp_valid), 0);
      check(cmd_ready == 1'b1, "R5", "ready after reply", int'(cmd_ready), 1);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL R5 watchdog: actual %0d cycles expected below 150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pb_en == 1'b0, "R1", "reset strobe", int'(pb_en), 0);
    check(pb_rd_nwr == 1'b1, "R1", "reset direction", int'(pb_rd_nwr), 1);
    check(cmd_ready == 1'b1, "R1", "reset ready", int'(cmd_ready), 1);
    check(rsp_valid == 1'b0, "R1", "reset reply", int'(rsp_valid), 0);
    rst = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(pb_en == 1'b0, "R8", "no strobe without command", int'(pb_en), 0);
    end
    for (int a = 0; a < 128; a++) run_cmd(1'b1, 1'b0, a, (a * 5 + 3) & 255, 0);
    for (int a = 0; a < 128; a++) run_cmd(1'b0, 1'b0, a, 0, a % 4);
    for (int b = 0; b < 32; b++) run_cmd(b[0], 1'b1, 127 - b, (b * 29 + 7) & 255, 0);
    run_cmd(1'b0, 1'b0, 127, 0, 7);
    run_cmd(1'b1, 1'b0, 0, 255, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(cmd_ready == 1'b1 && pb_rd_nwr == 1'b1, "R1", "idle after second reset",
          int'(cmd_ready & pb_rd_nwr), 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule